// File: doc/BRIEF.md
# Single-to-Double Float Format Expander

This block accepts a 32-bit IEEE single-precision bit pattern and produces the equivalent 64-bit double-precision register image. The conversion is exact. Neither rounding nor exception reporting is involved. There are three paths:

- Normal inputs are widened by copying exponent bits.
- Subnormal inputs are renormalized into a true double exponent with an explicit one-pass shift.
- Zero, infinity and NaN inputs pass through under the opposite bit-copying rule.

Words enter and leave on valid/ready streams with one register stage between them. Bit positions below use the usual `[msb:0]` numbering: input bit 31 and output bit 63 are the sign.

Back-pressure rules:

- An input word is taken on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty or the consumer takes the current result in the same cycle.
- A result stays on `out_dword`, with `out_valid` high, until `out_ready` is seen high.
- The producer may hold or change `in_word` freely while `in_ready` is low. The word is only taken at a handshake.

Top module: `s2d_expand`

## Requirements
- R1: For an input whose exponent field in[30:23] lies in 1..254, out[63:62] = in[31:30], out[61], out[60] and out[59] each equal the inverse of in[30], out[58:29] = in[29:0], and out[28:0] are zero.
- R2: For an input with exponent field 255, or with exponent field 0 and fraction in[22:0] zero, out[63:62] = in[31:30], out[61:59] each equal in[30] (not inverted), out[58:29] = in[29:0], and out[28:0] are zero.
- R3: For an input with exponent field 0 and nonzero fraction f = in[22:0], let z be the count of leading zeros of f as a 23-bit value. Then out[62:52] = 896 - z and out[51:0] = {bits 22..0 of (f << (z+1)), 29 zero bits}, the leading one being dropped.
- R4: out[63] always equals in[31] of the word that produced it.
- R5: A word accepted on one clock edge appears on `out_dword` with `out_valid` high after the next clock edge (latency 1), and back-to-back words stream at one per cycle while `out_ready` stays high.
- R6: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_valid` and `out_dword` keep their values.
- R7: A synchronous active-high `rst` clears `out_valid` and `out_dword` to zero.
- R8: A clock edge with `in_ready` high and `in_valid` low drops `out_valid` and leaves `out_dword` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept an input word this cycle |
| in_word | input | 32 | Single-precision bit pattern |
| out_valid | output | 1 | Output pattern valid |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_dword | output | 64 | Double-precision bit pattern |

## Verification
The bench builds the block with its default field widths: an 8-bit exponent and 23-bit fraction in, and a 52-bit fraction out. At these widths every one of the 256 exponent codes can be swept for both signs under several fraction patterns, which covers every boundary between the normal, zero, subnormal and infinity/NaN paths.

Subnormals are driven at every leading-zero count from 0 to 22, both as a single set bit and as a run of ones. This reaches the smallest and largest subnormal and every shift amount of the renormalizer. Each of these results is compared against an iterative, arithmetic reference model.

A stalled consumer is exercised so that the hold and ready rules can be observed at the ports.

// File: rtl/s2d_pkg.sv
package s2d_pkg;
  typedef enum logic [1:0] {
    CLS_NORM    = 2'd0,
    CLS_SUB     = 2'd1,
    CLS_SPECIAL = 2'd2
  } s2d_cls_e;
endpackage

// File: rtl/s2d_classify.sv
module s2d_classify
  import s2d_pkg::*;
#(
  parameter int SEXP_W  = 8,
  parameter int SFRAC_W = 23
) (
  input  logic [SEXP_W-1:0]  exp_f,
  input  logic [SFRAC_W-1:0] frac_f,
  output s2d_cls_e           cls
);
  logic exp_zero, exp_ones, frac_zero;

  always_comb begin
    exp_zero  = (exp_f == '0);
    exp_ones  = (exp_f == '1);
    frac_zero = (frac_f == '0);
    if (!exp_zero && !exp_ones) cls = CLS_NORM;
    else if (exp_zero && !frac_zero) cls = CLS_SUB;
    else cls = CLS_SPECIAL;
  end
endmodule

// File: rtl/s2d_lzc.sv
module s2d_lzc #(
  parameter int W = 23,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  logic [W-1:0] above;
  logic [W-1:0] first;

  // above[i]: some bit more significant than i is set
  generate
    for (genvar i = 0; i < W; i++) begin : g_scan
      if (i == W - 1) begin : g_top
        assign above[i] = 1'b0;
      end else begin : g_mid
        assign above[i] = above[i+1] | vec[i+1];
      end
      assign first[i] = vec[i] & ~above[i];
    end
  endgenerate

  always_comb begin
    cnt = (vec == '0) ? CW'(W) : '0;
    for (int i = 0; i < W; i++) begin
      if (first[i]) cnt = cnt | CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/s2d_widen_core.sv
module s2d_widen_core
  import s2d_pkg::*;
#(
  parameter int SEXP_W  = 8,
  parameter int SFRAC_W = 23,
  parameter int DFRAC_W = 52,
  localparam int DEXP_W = SEXP_W + 3,
  localparam int SW     = 1 + SEXP_W + SFRAC_W,
  localparam int DW     = 1 + DEXP_W + DFRAC_W,
  localparam int PAD    = DFRAC_W - SFRAC_W,
  localparam int LZW    = $clog2(SFRAC_W + 1)
) (
  input  logic [SW-1:0]  word,
  input  s2d_cls_e       cls,
  input  logic [LZW-1:0] lz,
  output logic [DW-1:0]  dword
);
  localparam int SBIAS    = (1 << (SEXP_W - 1)) - 1;
  localparam int DBIAS    = (1 << (DEXP_W - 1)) - 1;
  localparam int SUB_BASE = DBIAS - SBIAS;

  logic                sgn;
  logic [SEXP_W-1:0]   ef;
  logic [SFRAC_W-1:0]  ff;
  logic [SFRAC_W-1:0]  aligned;
  logic [SFRAC_W-1:0]  sub_frac;
  logic [DEXP_W-1:0]   sub_exp;
  logic [DEXP_W-1:0]   exp_out;
  logic [SFRAC_W-1:0]  frac_out;

  always_comb begin
    sgn      = word[SW-1];
    ef       = word[SW-2 -: SEXP_W];
    ff       = word[SFRAC_W-1:0];
    aligned  = ff << lz;
    sub_frac = {aligned[SFRAC_W-2:0], 1'b0};
    sub_exp  = DEXP_W'(SUB_BASE) - DEXP_W'(lz);
    unique case (cls)
      CLS_NORM: begin
        exp_out  = {ef[SEXP_W-1], {3{~ef[SEXP_W-1]}}, ef[SEXP_W-2:0]};
        frac_out = ff;
      end
      CLS_SUB: begin
        exp_out  = sub_exp;
        frac_out = sub_frac;
      end
      default: begin
        exp_out  = {ef[SEXP_W-1], {3{ef[SEXP_W-1]}}, ef[SEXP_W-2:0]};
        frac_out = ff;
      end
    endcase
    dword = {sgn, exp_out, frac_out, {PAD{1'b0}}};
  end
endmodule

// File: rtl/s2d_expand.sv
module s2d_expand
  import s2d_pkg::*;
#(
  parameter int SEXP_W  = 8,
  parameter int SFRAC_W = 23,
  parameter int DFRAC_W = 52,
  localparam int SW     = 1 + SEXP_W + SFRAC_W,
  localparam int DW     = 1 + SEXP_W + 3 + DFRAC_W,
  localparam int LZW    = $clog2(SFRAC_W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [SW-1:0] in_word,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_dword
);
  s2d_cls_e       cls;
  logic [LZW-1:0] lz;
  logic [DW-1:0]  wide;

  s2d_classify #(.SEXP_W(SEXP_W), .SFRAC_W(SFRAC_W)) u_cls (
    .exp_f  (in_word[SW-2 -: SEXP_W]),
    .frac_f (in_word[SFRAC_W-1:0]),
    .cls    (cls)
  );

  s2d_lzc #(.W(SFRAC_W)) u_lzc (
    .vec (in_word[SFRAC_W-1:0]),
    .cnt (lz)
  );

  s2d_widen_core #(.SEXP_W(SEXP_W), .SFRAC_W(SFRAC_W), .DFRAC_W(DFRAC_W)) u_core (
    .word  (in_word),
    .cls   (cls),
    .lz    (lz),
    .dword (wide)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_dword <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_dword <= wide;
    end
  end
endmodule

// File: rtl/s2d_expand_chk.sv
module s2d_expand_chk #(
  parameter int SEXP_W  = 8,
  parameter int SFRAC_W = 23,
  parameter int DFRAC_W = 52,
  localparam int SW     = 1 + SEXP_W + SFRAC_W,
  localparam int DW     = 1 + SEXP_W + 3 + DFRAC_W
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic [SW-1:0] in_word,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_dword
);
  logic take, is_norm, is_spec, is_sub;
  assign take    = in_valid && in_ready && !rst;
  assign is_norm = (in_word[SW-2 -: SEXP_W] != '0) && (in_word[SW-2 -: SEXP_W] != '1);
  assign is_sub  = (in_word[SW-2 -: SEXP_W] == '0) && (in_word[SFRAC_W-1:0] != '0);
  assign is_spec = !is_norm && !is_sub;

  assert_norm_invert_R1: assert property (@(posedge clk) disable iff (rst)
    (take && is_norm) |=> (out_dword[DW-3 -: 3] == {3{~$past(in_word[SW-2])}}));

  assert_spec_copy_R2: assert property (@(posedge clk) disable iff (rst)
    (take && is_spec) |=> (out_dword[DW-3 -: 3] == {3{$past(in_word[SW-2])}}));

  assert_sub_exp_range_R3: assert property (@(posedge clk) disable iff (rst)
    (take && is_sub) |=> (!out_dword[DW-2] && out_dword[DW-2 -: SEXP_W+3] != '0));

  assert_sign_kept_R4: assert property (@(posedge clk) disable iff (rst)
    take |=> (out_dword[DW-1] == $past(in_word[SW-1])));

  assert_latency_one_R5: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid);

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_dword)));

  assert_reset_clear_R7: assert property (@(posedge clk)
    rst |=> (!out_valid && out_dword == '0));

  assert_idle_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> (!out_valid && $stable(out_dword)));
endmodule

bind s2d_expand s2d_expand_chk #(
  .SEXP_W(SEXP_W), .SFRAC_W(SFRAC_W), .DFRAC_W(DFRAC_W)
) u_chk (.*);

// File: tb/sim_s2d_expand.sv
module sim_s2d_expand;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_word;
  logic        out_valid;
  logic        out_ready;
  logic [63:0] out_dword;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  s2d_expand u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_dword(out_dword)
  );

  function automatic logic [63:0] ref_widen(input logic [31:0] w);
    logic        s;
    logic [7:0]  e;
    logic [22:0] f;
    logic [52:0] m;
    int          x;
    s = w[31]; e = w[30:23]; f = w[22:0];
    if (e != 8'd0 && e != 8'd255) return {s, 11'(int'(e) + 896), f, 29'b0};
    if (e == 8'd255) return {s, 11'h7FF, f, 29'b0};
    if (f == 23'd0) return {s, 11'h000, 23'd0, 29'b0};
    x = -126;
    m = {1'b0, f, 29'b0};
    while (!m[52]) begin
      m = m << 1;
      x = x - 1;
    end
    return {s, 11'(x + 1023), m[51:0]};
  endfunction

  function automatic string tag_of(input logic [31:0] w);
    if (w[30:23] != 8'd0 && w[30:23] != 8'd255) return "R1";
    if (w[30:23] == 8'd0 && w[22:0] != 23'd0) return "R3";
    return "R2";
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one word, sample after the capturing edge (latency 1)
  task automatic send(input logic [31:0] w);
    logic [63:0] e;
    e = ref_widen(w);
    in_word  = w;
    in_valid = 1'b1;
    @(negedge clk);
    chk("R5", 64'(out_valid), 64'd1);
    chk(tag_of(w), out_dword, e);
    chk("R4", 64'(out_dword[63]), 64'(w[31]));
  endtask

  initial begin
    logic [22:0] pats [4];
    logic [63:0] held;
    pats[0] = 23'd0; pats[1] = 23'd1; pats[2] = 23'h400000; pats[3] = 23'h2AAAAA;
    rst = 1'b1; in_valid = 1'b0; in_word = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7", 64'(out_valid), 64'd0);
    chk("R7", out_dword, 64'd0);
    rst = 1'b0;

    // full exponent sweep, both signs (R1, R2, R3 at exponent 0)
    for (int s = 0; s < 2; s++)
      for (int e = 0; e < 256; e++)
        for (int k = 0; k < 4; k++)
          send({1'(s), 8'(e), pats[k]});

    // subnormals at every leading-zero count, smallest to largest (R3)
    for (int s = 0; s < 2; s++)
      for (int p = 0; p < 23; p++) begin
        send({1'(s), 8'd0, 23'(1 << p)});
        send({1'(s), 8'd0, 23'((1 << (p + 1)) - 1)});
      end

    // quiet NaN and infinities (R2)
    send(32'h7FC00000);
    send(32'h7F800000);
    send(32'hFF800000);
    send(32'h80000000);

    // idle cycle: valid drops, data retained (R8)
    held = out_dword;
    in_valid = 1'b0;
    @(negedge clk);
    chk("R8", 64'(out_valid), 64'd0);
    chk("R8", out_dword, held);

    // back-pressure (R6)
    out_ready = 1'b0;
    in_word = 32'h3F800000; in_valid = 1'b1;
    @(negedge clk);
    chk("R5", out_dword, ref_widen(32'h3F800000));
    in_word = 32'h00000001;
    chk("R6", 64'(in_ready), 64'd0);
    repeat (2) begin
      @(negedge clk);
      chk("R6", 64'(out_valid), 64'd1);
      chk("R6", out_dword, ref_widen(32'h3F800000));
      chk("R6", 64'(in_ready), 64'd0);
    end
    out_ready = 1'b1;
    #1;
    chk("R6", 64'(in_ready), 64'd1);
    @(negedge clk);
    chk("R3", out_dword, ref_widen(32'h00000001));
    in_valid = 1'b0;
    @(negedge clk);
    chk("R8", 64'(out_valid), 64'd0);

    // reset mid-stream (R7)
    in_word = 32'hC0490FDB; in_valid = 1'b1;
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    chk("R7", 64'(out_valid), 64'd0);
    chk("R7", out_dword, 64'd0);
    rst = 1'b0;
    @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule